// File: doc/BRIEF.md
# Queue Error Collector with First-Error Capture

This block gathers error pulses from a set of crossbar queues into sticky per-queue error registers and keeps a single record of the earliest error it sees. Each queue has its own register. Each bit of that register marks one error condition on one channel: request or reply. Queues at the lower source numbers are output queues. Queues at the higher source numbers are input queues. Each kind keeps only the conditions it can raise.

The first-error record holds an error type, a channel, a source number and a valid flag. While the record is valid, the block drives an interrupt to two processor interfaces. Software clears the record in a fixed order. First it clears the queue register that logged the error, through a clear address. Then it clears the record. A clear done in the wrong order leaves the record and the interrupt in place. A software write to a queue register also arms the record, so software can exercise the interrupt path without a real fault.

The register bus is a plain single-cycle port with no back-pressure. A write is taken on the clock edge where `reg_wr` is high, and read data follows `reg_addr` combinationally. Error pulses are one-cycle strobes. They are never stalled and never dropped.

Top module: `err_first_capture`

## Requirements
- R1: A pulse on `err_pulse` bit `s*10 + cond*2 + chan` sets bit `cond*2 + chan` of the register for source `s`. The register reads at address `8*s`, and the bit stays set until that register is cleared or written. The condition codes are overflow 0, underflow 1, tail timeout 2, deadlock timeout 3 and invalid select 4. The channel is 0 for request and 1 for reply.
- R2: Output queues (sources below `NUM_OQ`) keep every condition except deadlock timeout. Input queues keep only overflow and deadlock timeout. A pulse or written bit for a condition a queue does not keep is ignored: it reads back 0 and does not arm the record.
- R3: The first-error record reads at address 0x80. Bits 3:0 hold the type (the condition code), bits 7:4 the channel, bits 11:8 the source and bit 12 the valid flag. The record loads only while it is not valid, and later errors never overwrite it.
- R4: When several sources report in the same cycle, the lowest-numbered source wins the record. Within one source, the lowest register bit wins. Every pulse still sets its own sticky bit.
- R5: `irq_cpu0` and `irq_cpu1` are both high exactly while the record is valid.
- R6: A write of any data to a queue's read address plus 0x100 clears that whole register. A pulse arriving in the same cycle is still recorded.
- R7: A write to 0x180 clears the record only when every queue register is zero in that cycle. Otherwise the record and the interrupt stay unchanged.
- R8: A write to a queue's read address stores the written data, masked as in R2, and arms the record with that source. The type and channel come from the lowest set bit of the stored data, or are 0 and 0 when no bit is set. A hardware pulse to the same queue in the same cycle takes precedence for the record.
- R9: The record cannot be written: a write to 0x80 has no effect. Reads of the clear addresses and of unused addresses return 0.
- R10: After reset, all queue registers and the record are zero and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | (NUM_OQ+NUM_IQ)*10 | Error strobes, 10 per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq_cpu0 | output | 1 | Interrupt to processor interface 0 |
| irq_cpu1 | output | 1 | Interrupt to processor interface 1 |

## Verification
The bench sweeps every source and every register bit. This catches a wrong bit position, a wrong type or channel encoding, and a kind mask that keeps a condition it should drop or loses one it should keep. It clears the record before the queue register and expects the interrupt to stay high; a design without the busy gate would drop the interrupt while an error is still logged. It also drives simultaneous, back-to-back and same-cycle pulse-and-clear traffic. Reversed priority would name the wrong source, an overwrite would replace the first record with a later one, and a clear that beats the set would lose a pulse. Test writes, including all-zero data and a write to the record address, show whether software arming and write protection behave.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int COND_N   = 5;
  localparam int CHAN_N   = 2;
  localparam int QBITS    = COND_N * CHAN_N;
  localparam int FIELD_W  = 4;
  localparam int Q_STRIDE = 8;
  localparam int FE_ADDR  = 'h80;
  localparam int CLR_OFS  = 'h100;

  typedef enum logic [FIELD_W-1:0] {
    ET_OVF  = 4'd0,
    ET_UNF  = 4'd1,
    ET_TAIL = 4'd2,
    ET_DLK  = 4'd3,
    ET_XSEL = 4'd4
  } err_type_e;

  typedef struct packed {
    logic               valid;
    logic [FIELD_W-1:0] source;
    logic [FIELD_W-1:0] channel;
    logic [FIELD_W-1:0] etype;
  } first_rec_t;

  // Conditions a queue of the given kind can log.
  function automatic logic [QBITS-1:0] kind_mask(input bit is_in);
    logic [QBITS-1:0] m;
    m = '0;
    for (int c = 0; c < COND_N; c++) begin
      for (int ch = 0; ch < CHAN_N; ch++) begin
        if (is_in ? (c == int'(ET_OVF) || c == int'(ET_DLK)) : (c != int'(ET_DLK)))
          m[c*CHAN_N + ch] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/errcap_queue.sv
module errcap_queue
  import errcap_pkg::*;
#(
  parameter bit IS_IN  = 1'b0,
  parameter int SRC_ID = 0,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [QBITS-1:0]   pulse,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [QBITS-1:0]   qreg,
  output logic               evt,
  output logic [FIELD_W-1:0] evt_type,
  output logic [FIELD_W-1:0] evt_chan
);
  localparam logic [QBITS-1:0] MASK = kind_mask(IS_IN);
  localparam int RD_ADDR = SRC_ID * Q_STRIDE;
  localparam int CL_ADDR = RD_ADDR + CLR_OFS;
  localparam int IDX_W   = $clog2(QBITS);

  logic             hit_wr, hit_clr, pulse_any;
  logic [QBITS-1:0] pm, wm, sel;
  logic [IDX_W-1:0] idx;

  assign hit_wr    = wr_en && (wr_addr == ADDR_W'(RD_ADDR));
  assign hit_clr   = wr_en && (wr_addr == ADDR_W'(CL_ADDR));
  assign pm        = pulse & MASK;
  assign wm        = wr_data[QBITS-1:0] & MASK;
  assign pulse_any = |pm;

  always_ff @(posedge clk) begin
    if (!rst_n)       qreg <= '0;
    else if (hit_wr)  qreg <= wm | pm;
    else if (hit_clr) qreg <= pm;
    else              qreg <= qreg | pm;
  end

  // Event candidate for the first-error record: pulses before a test write.
  always_comb begin
    sel = pulse_any ? pm : wm;
    idx = '0;
    for (int b = QBITS-1; b >= 0; b--) begin
      if (sel[b]) idx = IDX_W'(b);
    end
  end

  assign evt      = pulse_any || hit_wr;
  assign evt_type = FIELD_W'(idx >> 1);
  assign evt_chan = FIELD_W'(idx[0]);
endmodule

// File: rtl/errcap_pick.sv
module errcap_pick
  import errcap_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0]              evt,
  input  logic [NSRC-1:0][FIELD_W-1:0] evt_type,
  input  logic [NSRC-1:0][FIELD_W-1:0] evt_chan,
  output logic                         pick_any,
  output logic [FIELD_W-1:0]           pick_type,
  output logic [FIELD_W-1:0]           pick_chan,
  output logic [FIELD_W-1:0]           pick_src
);
  // Lowest-numbered source wins.
  always_comb begin
    pick_type = '0;
    pick_chan = '0;
    pick_src  = '0;
    for (int s = NSRC-1; s >= 0; s--) begin
      if (evt[s]) begin
        pick_type = evt_type[s];
        pick_chan = evt_chan[s];
        pick_src  = FIELD_W'(s);
      end
    end
  end

  assign pick_any = |evt;
endmodule

// File: rtl/errcap_first.sv
module errcap_first
  import errcap_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [FIELD_W-1:0] arm_type,
  input  logic [FIELD_W-1:0] arm_chan,
  input  logic [FIELD_W-1:0] arm_src,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic               q_busy,
  output first_rec_t         rec
);
  localparam int FE_CLR = FE_ADDR + CLR_OFS;

  logic clr_ok;
  assign clr_ok = wr_en && (wr_addr == ADDR_W'(FE_CLR)) && !q_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec <= '0;
    end else if (arm && (!rec.valid || clr_ok)) begin
      rec <= '{valid: 1'b1, source: arm_src, channel: arm_chan, etype: arm_type};
    end else if (clr_ok) begin
      rec <= '0;
    end
  end
endmodule

// File: rtl/err_first_capture.sv
module err_first_capture
  import errcap_pkg::*;
#(
  parameter int NUM_OQ = 2,
  parameter int NUM_IQ = 2,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [(NUM_OQ+NUM_IQ)*QBITS-1:0]   err_pulse,
  input  logic                               reg_wr,
  input  logic [ADDR_W-1:0]                  reg_addr,
  input  logic [DATA_W-1:0]                  reg_wdata,
  output logic [DATA_W-1:0]                  reg_rdata,
  output logic                               irq_cpu0,
  output logic                               irq_cpu1
);
  localparam int NSRC = NUM_OQ + NUM_IQ;

  logic [QBITS-1:0]             qreg [NSRC];
  logic [NSRC-1:0]              evt;
  logic [NSRC-1:0][FIELD_W-1:0] evt_type;
  logic [NSRC-1:0][FIELD_W-1:0] evt_chan;
  logic                         pick_any;
  logic [FIELD_W-1:0]           pick_type, pick_chan, pick_src;
  logic                         q_busy;
  first_rec_t                   fe_rec;

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_q
      errcap_queue #(
        .IS_IN (s >= NUM_OQ),
        .SRC_ID(s),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
      ) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (err_pulse[s*QBITS +: QBITS]),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .qreg    (qreg[s]),
        .evt     (evt[s]),
        .evt_type(evt_type[s]),
        .evt_chan(evt_chan[s])
      );
    end
  endgenerate

  errcap_pick #(.NSRC(NSRC)) u_pick (
    .evt      (evt),
    .evt_type (evt_type),
    .evt_chan (evt_chan),
    .pick_any (pick_any),
    .pick_type(pick_type),
    .pick_chan(pick_chan),
    .pick_src (pick_src)
  );

  always_comb begin
    q_busy = 1'b0;
    for (int i = 0; i < NSRC; i++) q_busy = q_busy | (|qreg[i]);
  end

  errcap_first #(.ADDR_W(ADDR_W)) u_first (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (pick_any),
    .arm_type(pick_type),
    .arm_chan(pick_chan),
    .arm_src (pick_src),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .q_busy  (q_busy),
    .rec     (fe_rec)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_addr == ADDR_W'(i*Q_STRIDE)) reg_rdata = DATA_W'(qreg[i]);
    end
    if (reg_addr == ADDR_W'(FE_ADDR)) reg_rdata = DATA_W'(fe_rec);
  end

  assign irq_cpu0 = fe_rec.valid;
  assign irq_cpu1 = fe_rec.valid;
endmodule

// File: rtl/errcap_chk.sv
module errcap_chk
  import errcap_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              q_busy,
  input logic [12:0]       rec,
  input logic              irq0,
  input logic              irq1
);
  localparam logic [ADDR_W-1:0] FE_CLR_A = ADDR_W'(FE_ADDR + CLR_OFS);

  // R3: a valid record changes only under a record-clear write
  assert_hold_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec[12] && !(reg_wr && reg_addr == FE_CLR_A)) |=> $stable(rec));

  // R7: the record drops only after a clear while no queue register is set
  assert_clear_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec[12]) |-> ($past(!q_busy) && $past(reg_wr && reg_addr == FE_CLR_A)));

  // R1: logged errors persist while no write occurs
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_busy && !reg_wr) |=> q_busy);

  // R5: both interrupt pins agree and follow the record
  assert_irq_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0 == irq1) && (irq0 == rec[12]));
endmodule

bind err_first_capture errcap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_wr  (reg_wr),
  .reg_addr(reg_addr),
  .q_busy  (q_busy),
  .rec     (fe_rec),
  .irq0    (irq_cpu0),
  .irq1    (irq_cpu1)
);

// File: tb/sim_err_first_capture.sv
`timescale 1ns/1ps
module sim_err_first_capture;
  localparam int NOQ = 2, NIQ = 2, NS = NOQ + NIQ, QB = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS*QB-1:0] err_pulse = '0;
  logic          reg_wr = 1'b0;
  logic [8:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          irq_cpu0, irq_cpu1;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  err_first_capture #(.NUM_OQ(NOQ), .NUM_IQ(NIQ), .ADDR_W(9), .DATA_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit keeps(input int s, input int b);
    int c = b / 2;
    return (s >= NOQ) ? (c == 0 || c == 3) : (c != 3);
  endfunction

  function automatic logic [15:0] rec_val(input int s, input int b);
    return 16'h1000 | 16'(s << 8) | 16'((b % 2) << 4) | 16'(b / 2);
  endfunction

  // One cycle of stimulus, starting and ending at a falling edge.
  task automatic step(input logic [NS*QB-1:0] p, input bit wr, input int addr, input int data);
    err_pulse = p; reg_wr = wr; reg_addr = 9'(addr); reg_wdata = 16'(data);
    @(negedge clk);
    err_pulse = '0; reg_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [15:0] v);
    reg_addr = 9'(addr);
    #1;
    v = reg_rdata;
  endtask

  task automatic clear_all();
    for (int s = 0; s < NS; s++) step('0, 1'b1, 'h100 + 8*s, 0);
    step('0, 1'b1, 'h180, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int s = 0; s < NS; s++) begin rd(8*s, v); check("R10 queue reset", v, 16'h0); end
    rd('h80, v); check("R10 record reset", v, 16'h0);
    check("R10 irq reset", {14'b0, irq_cpu1, irq_cpu0}, 16'h0);

    // R1 R2 R3 R5 R6 R7 sweep over every source and bit
    for (int s = 0; s < NS; s++) begin
      for (int b = 0; b < QB; b++) begin
        logic [NS*QB-1:0] p;
        bit k;
        k = keeps(s, b);
        p = '0; p[s*QB + b] = 1'b1;
        step(p, 1'b0, 0, 0);
        rd(8*s, v); check("R1/R2 sticky bit", v, k ? 16'(1 << b) : 16'h0);
        rd('h80, v); check("R3 record", v, k ? rec_val(s, b) : 16'h0);
        check("R5 irq", {14'b0, irq_cpu1, irq_cpu0}, k ? 16'h3 : 16'h0);
        if (k) begin
          step('0, 1'b1, 'h180, 0);
          rd('h80, v); check("R7 wrong-order clear kept", v, rec_val(s, b));
          check("R7 irq held", {15'b0, irq_cpu0}, 16'h1);
          step('0, 1'b1, 'h100 + 8*s, 0);
          rd(8*s, v); check("R6 queue clear", v, 16'h0);
          step('0, 1'b1, 'h180, 0);
          rd('h80, v); check("R7 record cleared", v, 16'h0);
          check("R5 irq low", {15'b0, irq_cpu0}, 16'h0);
        end
      end
    end

    // R4 simultaneous: source 3 overflow request with source 1 underflow reply
    begin
      logic [NS*QB-1:0] p;
      p = '0; p[3*QB + 0] = 1'b1; p[1*QB + 3] = 1'b1;
      step(p, 1'b0, 0, 0);
      rd('h80, v); check("R4 lowest source wins", v, 16'h1111);
      rd(8, v);  check("R4 src1 sticky", v, 16'h0008);
      rd(24, v); check("R4 src3 sticky", v, 16'h0001);
      clear_all();
      // within one source: bits 5 and 2 at once, bit 2 wins
      p = '0; p[5] = 1'b1; p[2] = 1'b1;
      step(p, 1'b0, 0, 0);
      rd('h80, v); check("R4 lowest bit wins", v, 16'h1001);
      rd(0, v); check("R4 both bits sticky", v, 16'h0024);
      clear_all();
      // R3 back-to-back: source 2 deadlock reply, then source 0 overflow
      p = '0; p[2*QB + 7] = 1'b1;
      step(p, 1'b0, 0, 0);
      p = '0; p[0] = 1'b1;
      step(p, 1'b0, 0, 0);
      rd('h80, v); check("R3 no overwrite", v, 16'h1213);
      clear_all();
      // R6 pulse in the same cycle as a clear survives
      step('0, 1'b1, 0, 'h0004);
      p = '0; p[1] = 1'b1;
      step(p, 1'b1, 'h100, 0);
      rd(0, v); check("R6 set beats clear", v, 16'h0002);
      clear_all();
    end

    // R8 software arming
    step('0, 1'b1, 8, 'h0010);
    rd(8, v); check("R8 stored", v, 16'h0010);
    rd('h80, v); check("R8 armed tail", v, 16'h1102);
    clear_all();
    step('0, 1'b1, 16, 'h03FF);
    rd(16, v); check("R8 input queue masked", v, 16'h00C3);
    rd('h80, v); check("R8 armed input", v, 16'h1200);
    clear_all();
    step('0, 1'b1, 0, 0);
    rd('h80, v); check("R8 zero write arms", v, 16'h1000);
    step('0, 1'b1, 'h180, 0);
    rd('h80, v); check("R8 zero-arm clear", v, 16'h0000);

    // R9 record not writable, clear addresses read zero
    step('0, 1'b1, 'h80, 'h1FFF);
    rd('h80, v); check("R9 record write ignored", v, 16'h0000);
    check("R9 irq low", {15'b0, irq_cpu1}, 16'h0);
    step('0, 1'b1, 0, 'h0001);
    rd('h100, v); check("R9 clear address reads 0", v, 16'h0000);
    rd('h1F8, v); check("R9 unused address reads 0", v, 16'h0000);
    clear_all();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule